// File: doc/BRIEF.md
# Audio Port Interrupt Status Unit with Frame-Match Timer

This unit collects event strobes from an audio serial engine and turns them into one interrupt line. Each of eight event sources owns an enable bit and a sticky pending bit. The pairs sit in the upper half of a single 32-bit control word. Software enables sources by writing that word. It acknowledges an event by writing 1 to the event's pending position.

The unit also keeps a 32-bit frame counter that advances once per frame tick, and a frame-match register. When a tick moves the counter onto the match value, the frame-count source becomes pending. Software uses this to get an interrupt after a chosen number of audio frames. All registers sit behind a simple port. Writes take effect on a single-cycle write strobe. Reads are combinational from the address.

Top module: `aud_irq_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Source k (k=0..7) has its enable at control-word bit 17+2k and its pending flag at bit 16+2k. The sources are: k=7 frame match, k=6..0 driven by `evt_i[6..0]` (6 message, 5 new peak, 4 clocks stopped, 3 sync error, 2 sync OK, 1 new sample rate, 0 status). Bits 15:0 always read 0.
- R3: A strobe on a source sets its pending bit whatever its enable. The bit stays set until a control-word write has 1 at that pending position. Writing 0 there leaves it unchanged.
- R4: A control-word write loads every enable bit with the written value.
- R5: If a strobe and a write-1 clear hit the same pending bit in one cycle, the bit ends set.
- R6: `irq_o` is the registered OR over sources of enable AND pending. It follows the register state one clock later.
- R7: The frame counter (address 0x40) adds 1 per `frame_tick_i` and wraps from 2^32-1 to 0. A software write presets it, and a write in the same cycle as a tick takes the written value.
- R8: The frame-match pending bit (bit 30) sets on the edge where a tick steps the counter onto the match value. A software preset onto the match value does not set it.
- R9: The control word is at address 0x00 and the match register at 0x50, both read/write. Other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_tick_i | input | 1 | One-cycle strobe per audio frame |
| evt_i | input | 7 | Event strobes for sources 6..0 |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the ones where two agents touch the same bit in the same cycle. One case is a strobe that coincides with a write-1 clear on the same pending bit. The other is a counter preset that coincides with a frame tick. The bench drives the write strobe and the event or tick inputs together on one falling edge to create each collision. Frame-match on wrap is reached by presetting the counter to all ones with a match value of zero, so no long run of ticks is needed.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 8;
  localparam int unsigned N_SRC     = 8;
  localparam int unsigned FIELD_LSB = DW - 2 * N_SRC;
  localparam logic [AW-1:0] A_CTRL  = 8'h00;
  localparam logic [AW-1:0] A_COUNT = 8'h40;
  localparam logic [AW-1:0] A_MATCH = 8'h50;
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cnt_we_i,
  input  logic         match_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] match_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, match_q, cnt_inc;

  assign cnt_inc = cnt_q + W'(1);
  // only a counted step can hit; a preset never does
  assign hit_o   = tick_i && !cnt_we_i && (cnt_inc == match_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= '0;
    end else begin
      if (cnt_we_i)    cnt_q <= wdata_i;
      else if (tick_i) cnt_q <= cnt_inc;
      if (match_we_i)  match_q <= wdata_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;

  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_we_i |=> cnt_o == $past(cnt_o) + W'(1));
  // R7
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(wdata_i));
  // R8
  hit_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !match_we_i |=> cnt_o == match_o);
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   set_i,
  input  logic           wr_i,
  input  logic [2*N-1:0] wfield_i,
  output logic [N-1:0]   en_o,
  output logic [N-1:0]   pend_o,
  output logic           irq_o
);
  logic [N-1:0] en_q, pend_q, en_d, pend_d, clr;
  logic         irq_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    assign clr[k]    = wr_i && wfield_i[2*k];
    assign en_d[k]   = wr_i ? wfield_i[2*k+1] : en_q[k];
    // set dominates clear
    assign pend_d[k] = set_i[k] || (pend_q[k] && !clr[k]);

    // R5
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> pend_o[k]);
    // R3
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !set_i[k] && !wr_i |=> $stable(pend_o[k]));
    // R3
    zero_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && !wfield_i[2*k] && pend_o[k] |=> pend_o[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= |(en_q & pend_q);
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R6
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == |($past(en_o) & $past(pend_o)));
endmodule

// File: rtl/aud_irq_unit.sv
module aud_irq_unit
  import aud_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_tick_i,
  input  logic [N_SRC-2:0] evt_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic             sel_ctrl, sel_cnt, sel_match;
  logic             hit;
  logic [DW-1:0]    cnt, match, ctrl_word;
  logic [N_SRC-1:0] en, pend;

  assign sel_ctrl  = (addr_i == A_CTRL);
  assign sel_cnt   = (addr_i == A_COUNT);
  assign sel_match = (addr_i == A_MATCH);

  frame_timer #(.W(DW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (frame_tick_i),
    .cnt_we_i   (we_i && sel_cnt),
    .match_we_i (we_i && sel_match),
    .wdata_i    (wdata_i),
    .cnt_o      (cnt),
    .match_o    (match),
    .hit_o      (hit)
  );

  irq_bank #(.N(N_SRC)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    ({hit, evt_i}),
    .wr_i     (we_i && sel_ctrl),
    .wfield_i (wdata_i[DW-1:FIELD_LSB]),
    .en_o     (en),
    .pend_o   (pend),
    .irq_o    (irq_o)
  );

  assign ctrl_word[FIELD_LSB-1:0] = '0;
  for (genvar k = 0; k < N_SRC; k++) begin : g_pack
    assign ctrl_word[FIELD_LSB+2*k+1] = en[k];
    assign ctrl_word[FIELD_LSB+2*k]   = pend[k];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)  rdata_o = ctrl_word;
    if (sel_cnt)   rdata_o = cnt;
    if (sel_match) rdata_o = match;
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ctrl && !sel_cnt && !sel_match |-> rdata_o == '0);
  // R8
  frame_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> pend[N_SRC-1]);
endmodule

// File: tb/sim_aud_irq_unit.sv
module sim_aud_irq_unit;
  localparam int CLK_NS = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h40, A_MAT = 8'h50;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [6:0]  evt = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic        irq;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  aud_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_tick_i(tick), .evt_i(evt),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {expected irq, enables[7:0], strobes[6:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 8'h00, 7'h7F}, {1'b1, 8'h01, 7'h01}, {1'b0, 8'h40, 7'h01},
    {1'b1, 8'h40, 7'h40}, {1'b0, 8'hFF, 7'h00}, {1'b0, 8'h2A, 7'h55},
    {1'b1, 8'h14, 7'h04}
  };

  function automatic logic [31:0] word(input logic [7:0] en, input logic [7:0] pd);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      w[17+2*k] = en[k];
      w[16+2*k] = pd[k];
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [6:0] e, input logic t);
    @(negedge clk); evt = e; tick = t;
    @(negedge clk); evt = '0; tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 32'h0);
    rd(A_CNT, rv);  chk("R1 count", rv, 32'h0);
    rd(A_MAT, rv);  chk("R1 match", rv, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 R3 R4 R6 vector walk
    for (int i = 0; i < 7; i++) begin
      wr(A_CTRL, word(VEC[i][14:7], 8'hFF));
      pulse(VEC[i][6:0], 1'b0);
      rd(A_CTRL, rv);
      chk("R3 R4 R2 ctrl", rv, word(VEC[i][14:7], {1'b0, VEC[i][6:0]}));
      @(negedge clk);
      chk("R6 irq", {31'b0, irq}, {31'b0, VEC[i][15]});
    end

    // R8 match after counted ticks
    wr(A_CTRL, word(8'h00, 8'hFF));
    wr(A_CNT, 32'h0);
    wr(A_MAT, 32'd5);
    rd(A_MAT, rv); chk("R9 match rw", rv, 32'd5);
    for (int i = 0; i < 4; i++) pulse('0, 1'b1);
    rd(A_CTRL, rv); chk("R8 before match", rv, 32'h0);
    pulse('0, 1'b1);
    rd(A_CTRL, rv); chk("R8 on match", rv, 32'h4000_0000);
    rd(A_CNT, rv);  chk("R7 count", rv, 32'd5);

    // R7 R8 wrap onto match of zero
    wr(A_CTRL, word(8'h80, 8'hFF));
    wr(A_CNT, 32'hFFFF_FFFF);
    wr(A_MAT, 32'h0);
    pulse('0, 1'b1);
    rd(A_CNT, rv);  chk("R7 wrap", rv, 32'h0);
    rd(A_CTRL, rv); chk("R8 wrap hit", rv, 32'hC000_0000);
    @(negedge clk); chk("R6 irq frame", {31'b0, irq}, 32'h1);

    // R8 preset onto match value does not set
    wr(A_CTRL, word(8'h00, 8'hFF));
    wr(A_CNT, 32'h0);
    rd(A_CTRL, rv); chk("R8 preset", rv, 32'h0);

    // R7 write beats tick
    @(negedge clk); we = 1'b1; addr = A_CNT; wdata = 32'd10; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd(A_CNT, rv); chk("R7 write wins", rv, 32'd10);

    // R5 strobe and clear collide
    @(negedge clk); we = 1'b1; addr = A_CTRL; wdata = word(8'h00, 8'hFF); evt = 7'h40;
    @(negedge clk); we = 1'b0; evt = '0;
    rd(A_CTRL, rv); chk("R5 set wins", rv, 32'h1000_0000);

    // R3 zero keeps pending, R4 enables load
    wr(A_CTRL, 32'h2000_0000);
    rd(A_CTRL, rv); chk("R3 write0 keeps", rv, 32'h3000_0000);
    @(negedge clk); chk("R6 irq on", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, rv); chk("R4 enable off", rv, 32'h1000_0000);
    @(negedge clk); chk("R6 irq off", {31'b0, irq}, 32'h0);

    // R2 low half reads zero
    wr(A_CTRL, 32'h0000_FFFF);
    rd(A_CTRL, rv); chk("R2 low zero", rv, 32'h1000_0000);

    // R9 unmapped address
    wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h20, rv);  chk("R9 unmapped", rv, 32'h0);
    rd(A_MAT, rv);  chk("R9 match kept", rv, 32'h0);
    rd(A_CNT, rv);  chk("R9 count kept", rv, 32'd10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule